// File: doc/BRIEF.md
# Function Error Classifier and Signaler

This block sits inside one function of a serial point-to-point I/O endpoint. It receives one detected error event at a time. Each event carries a status word, a correctable/uncorrectable flag, a maybe-advisory flag and a 16-bit requester identifier. The block applies the supported-bit filter, the mask registers and the severity register to the event. It then updates the sticky correctable and uncorrectable status registers and the four error-detected bits of the device status. For unmasked uncorrectable errors it asks the neighbouring header-log block to capture the error. Finally it decides whether an outgoing error message is raised, and with which severity.

Two paths change the ordinary flow. A non-fatal uncorrectable event flagged maybe-advisory is reported as an advisory correctable error. When the header-log block answers a capture request with an overflow indication, the block processes a header-log-overflow correctable error of its own once the first message has been accepted. That error goes through the same rules and carries source identifier zero. Messages leave on a valid/ready handshake. The block takes no new event while a message is pending or the overflow error is still being handled. Forwarding the message onward is the job of other logic.

Top module: `errsig_classifier`

## Requirements
- R1: An event whose status, after filtering to the supported bits, does not have exactly one bit set is dropped. It changes no status bit, raises no capture request and sends no message. The supported correctable bits are 0, 6, 7, 8, 12, 13, 14 and 15. The supported uncorrectable bits are 0, 4, 5 and 12 through 25.
- R2: An accepted correctable event sets device status bit 0 (correctable detected) and sets its own bit in the correctable status register. Both status registers and the device status are sticky until reset.
- R3: A correctable event whose bit is set in the correctable mask stops after the status update. Otherwise it sends a correctable message if, and only if, correctable reporting is enabled.
- R4: The severity of an uncorrectable event comes from its bit in the severity input: 1 means fatal, 0 means non-fatal. An unmasked uncorrectable event raises a capture request for one cycle, with its filtered status bit on recordStatus. It sets its uncorrectable status bit and sets device status bit 2 (fatal) or bit 1 (non-fatal). If its bit is 20 (unsupported request), it also sets device status bit 3.
- R5: An uncorrectable event that is masked sets its uncorrectable status bit and its device status bits only. It raises no capture request and sends no message.
- R6: A non-fatal uncorrectable event with the maybe-advisory flag sets correctable status bit 13 and device status bit 0 instead of bit 1. If bit 13 is not masked in the correctable mask, it also sets its uncorrectable status bit and raises a capture request, unless that bit is masked in the uncorrectable mask. Its correctable message also needs unsupported-request reporting when its bit is 20.
- R7: An unmasked, non-advisory uncorrectable event sends a message when the system-error enable is set, or when the reporting enable for its severity is set. An unsupported request is suppressed when both unsupported-request reporting and the system-error enable are clear. The message severity code is one-hot: bit 0 correctable, bit 1 non-fatal, bit 2 fatal.
- R8: Sending an uncorrectable message with the system-error enable set sets the signaled-system-error output.
- R9: msgValid rises the cycle after the event is taken. Severity and source then stay stable until msgReady is seen. evtReady is low from the cycle after acceptance until the flow ends.
- R10: If the capture request was answered with overflow, then after the message is accepted the block processes a correctable error on bit 15 through the R2/R3 rules, with source identifier 0.
- R11: After reset all status outputs are zero, no message is pending and evtReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Error event present |
| evtReady | output | 1 | Block can take an event |
| evtCorr | input | 1 | Event is correctable |
| evtAdvisory | input | 1 | Event may be advisory non-fatal |
| evtStatus | input | 32 | Error status bit of the event |
| evtSourceId | input | SRC_W | Requester identifier of the event |
| serrEn | input | 1 | System-error enable |
| corRptEn | input | 1 | Correctable reporting enable |
| nfRptEn | input | 1 | Non-fatal reporting enable |
| fatRptEn | input | 1 | Fatal reporting enable |
| urRptEn | input | 1 | Unsupported-request reporting enable |
| corMask | input | 32 | Correctable mask |
| uncMask | input | 32 | Uncorrectable mask |
| uncSeverity | input | 32 | Uncorrectable severity, 1 = fatal |
| recordReq | output | 1 | Capture request to the header-log block |
| recordStatus | output | 32 | Status bit being captured |
| recordOverflow | input | 1 | Header-log block reports overflow, same cycle |
| corStatus | output | 32 | Correctable status register |
| uncStatus | output | 32 | Uncorrectable status register |
| devStatus | output | 4 | {UR, fatal, non-fatal, correctable} detected |
| sigSysErr | output | 1 | Signaled system error |
| msgValid | output | 1 | Error message pending |
| msgReady | input | 1 | Message taken |
| msgSeverity | output | 3 | One-hot {fatal, non-fatal, correctable} |
| msgSourceId | output | SRC_W | Source identifier of the message |

## Verification
All status state is carried straight to the ports, so a wrong update appears the cycle after the event is taken. A bit may be set in the wrong register, a mask may be applied in the wrong place, or the advisory reroute may miss. The bench compares the status outputs against a behavioural model on every clock. A broken sequencer shows up as a wrong value on evtReady or msgValid in the first cycle it diverges. A lost overflow flag is slower to see: it appears only after the first message is accepted, when bit 15 of the correctable status fails to rise. The overflow scenario therefore stalls the message to stretch that window.

// File: rtl/errsig_pkg.sv
package errsig_pkg;
  localparam int STAT_W = 32;
  localparam logic [STAT_W-1:0] COR_SUPPORTED = 32'h0000_F1C1;
  localparam logic [STAT_W-1:0] UNC_SUPPORTED = 32'h03FF_F031;
  localparam logic [STAT_W-1:0] UR_BIT        = 32'h0010_0000;
  localparam logic [STAT_W-1:0] ADV_BIT       = 32'h0000_2000;
  localparam logic [STAT_W-1:0] HLO_BIT       = 32'h0000_8000;
  localparam logic [STAT_W-1:0] SEV_DEFAULT   = 32'h0006_2031;

  typedef struct packed {
    logic apply;
    logic useHlo;
  } ctrlStrobe_t;

  typedef struct packed {
    logic sendMsg;
    logic recReq;
  } dpFlags_t;
endpackage

// File: rtl/errsig_datapath.sv
module errsig_datapath
  import errsig_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              evtCorr,
  input  logic              evtAdvisory,
  input  logic [STAT_W-1:0] evtStatus,
  input  logic [SRC_W-1:0]  evtSourceId,
  input  logic              serrEn,
  input  logic              corRptEn,
  input  logic              nfRptEn,
  input  logic              fatRptEn,
  input  logic              urRptEn,
  input  logic [STAT_W-1:0] corMask,
  input  logic [STAT_W-1:0] uncMask,
  input  logic [STAT_W-1:0] uncSeverity,
  output dpFlags_t          flags,
  output logic [STAT_W-1:0] recordStatus,
  output logic [STAT_W-1:0] corStatus,
  output logic [STAT_W-1:0] uncStatus,
  output logic [3:0]        devStatus,
  output logic              sigSysErr,
  output logic [2:0]        msgSeverity,
  output logic [SRC_W-1:0]  msgSourceId
);
  logic              selCorr, selAdv;
  logic [STAT_W-1:0] selStat, supBits, corBit;
  logic [SRC_W-1:0]  selSrc;
  logic              oneHot, isUr, isFatal, toCorr, corBlocked, uncBlocked;
  logic [STAT_W-1:0] nextCor, nextUnc;
  logic [3:0]        nextDev;
  logic              nextSse, doRec, doSend;
  logic [2:0]        sev;

  always_comb begin
    selCorr    = strobe.useHlo ? 1'b1 : evtCorr;
    selAdv     = strobe.useHlo ? 1'b0 : evtAdvisory;
    selStat    = strobe.useHlo ? HLO_BIT : evtStatus;
    selSrc     = strobe.useHlo ? '0 : evtSourceId;
    supBits    = selStat & (selCorr ? COR_SUPPORTED : UNC_SUPPORTED);
    oneHot     = (supBits != '0) && ((supBits & (supBits - 1'b1)) == '0);
    isUr       = !selCorr && (supBits == UR_BIT);
    isFatal    = !selCorr && |(supBits & uncSeverity);
    toCorr     = selCorr || (selAdv && !isFatal);
    corBit     = selCorr ? supBits : ADV_BIT;
    corBlocked = |(corBit & corMask);
    uncBlocked = |(supBits & uncMask);
  end

  always_comb begin
    nextCor = corStatus;
    nextUnc = uncStatus;
    nextDev = devStatus;
    nextSse = sigSysErr;
    doRec   = 1'b0;
    doSend  = 1'b0;
    sev     = 3'b000;
    if (strobe.apply && oneHot) begin
      if (isUr) nextDev[3] = 1'b1;
      if (toCorr) begin
        nextDev[0] = 1'b1;
        nextCor    = corStatus | corBit;
        if (!corBlocked) begin
          if (!selCorr) begin
            doRec   = !uncBlocked;
            nextUnc = uncStatus | supBits;
          end
          doSend = corRptEn && (!isUr || urRptEn);
          sev    = 3'b001;
        end
      end else begin
        if (isFatal) nextDev[2] = 1'b1;
        else         nextDev[1] = 1'b1;
        nextUnc = uncStatus | supBits;
        if (!uncBlocked) begin
          doRec  = 1'b1;
          doSend = !(isUr && !urRptEn && !serrEn) &&
                   (serrEn || (isFatal ? fatRptEn : nfRptEn));
          sev    = isFatal ? 3'b100 : 3'b010;
          if (doSend && serrEn) nextSse = 1'b1;
        end
      end
    end
  end

  assign flags.sendMsg = doSend;
  assign flags.recReq  = doRec;
  assign recordStatus  = supBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      corStatus   <= '0;
      uncStatus   <= '0;
      devStatus   <= '0;
      sigSysErr   <= 1'b0;
      msgSeverity <= '0;
      msgSourceId <= '0;
    end else begin
      corStatus <= nextCor;
      uncStatus <= nextUnc;
      devStatus <= nextDev;
      sigSysErr <= nextSse;
      if (doSend) begin
        msgSeverity <= sev;
        msgSourceId <= selSrc;
      end
    end
  end
endmodule

// File: rtl/errsig_control.sv
module errsig_control
  import errsig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic        msgReady,
  input  logic        recordOverflow,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe,
  output logic        evtReady,
  output logic        msgValid
);
  typedef enum logic [1:0] {IDLE, SEND, HLO} state_t;
  state_t state;
  logic   ovfPend;

  always_comb begin
    strobe.apply  = ((state == IDLE) && evtValid) || (state == HLO);
    strobe.useHlo = (state == HLO);
  end

  assign evtReady = (state == IDLE);
  assign msgValid = (state == SEND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      ovfPend <= 1'b0;
    end else begin
      case (state)
        IDLE: if (evtValid && flags.sendMsg) begin
          state   <= SEND;
          ovfPend <= flags.recReq && recordOverflow;
        end
        SEND: if (msgReady) begin
          state   <= ovfPend ? HLO : IDLE;
          ovfPend <= 1'b0;
        end
        HLO: state <= flags.sendMsg ? SEND : IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/errsig_classifier.sv
module errsig_classifier
  import errsig_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  output logic              evtReady,
  input  logic              evtCorr,
  input  logic              evtAdvisory,
  input  logic [STAT_W-1:0] evtStatus,
  input  logic [SRC_W-1:0]  evtSourceId,
  input  logic              serrEn,
  input  logic              corRptEn,
  input  logic              nfRptEn,
  input  logic              fatRptEn,
  input  logic              urRptEn,
  input  logic [STAT_W-1:0] corMask,
  input  logic [STAT_W-1:0] uncMask,
  input  logic [STAT_W-1:0] uncSeverity,
  output logic              recordReq,
  output logic [STAT_W-1:0] recordStatus,
  input  logic              recordOverflow,
  output logic [STAT_W-1:0] corStatus,
  output logic [STAT_W-1:0] uncStatus,
  output logic [3:0]        devStatus,
  output logic              sigSysErr,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [2:0]        msgSeverity,
  output logic [SRC_W-1:0]  msgSourceId
);
  ctrlStrobe_t strobe;
  dpFlags_t    flags;

  errsig_control u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .msgReady(msgReady),
    .recordOverflow(recordOverflow), .flags(flags), .strobe(strobe),
    .evtReady(evtReady), .msgValid(msgValid)
  );

  errsig_datapath #(.SRC_W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtCorr(evtCorr),
    .evtAdvisory(evtAdvisory), .evtStatus(evtStatus), .evtSourceId(evtSourceId),
    .serrEn(serrEn), .corRptEn(corRptEn), .nfRptEn(nfRptEn), .fatRptEn(fatRptEn),
    .urRptEn(urRptEn), .corMask(corMask), .uncMask(uncMask),
    .uncSeverity(uncSeverity), .flags(flags), .recordStatus(recordStatus),
    .corStatus(corStatus), .uncStatus(uncStatus), .devStatus(devStatus),
    .sigSysErr(sigSysErr), .msgSeverity(msgSeverity), .msgSourceId(msgSourceId)
  );

  assign recordReq = flags.recReq;
endmodule

// File: rtl/errsig_checker.sv
module errsig_checker
  import errsig_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtReady,
  input logic              serrEn,
  input logic              recordReq,
  input logic [STAT_W-1:0] recordStatus,
  input logic [STAT_W-1:0] corStatus,
  input logic [STAT_W-1:0] uncStatus,
  input logic              sigSysErr,
  input logic              msgValid,
  input logic              msgReady,
  input logic [2:0]        msgSeverity,
  input logic [SRC_W-1:0]  msgSourceId
);
  a_r9_msg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgSeverity) && $stable(msgSourceId)));

  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !evtReady);

  a_r7_sev_onehot: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> ($countones(msgSeverity) == 1));

  a_r2_cor_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((corStatus & $past(corStatus)) == $past(corStatus)));

  a_r4_unc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((uncStatus & $past(uncStatus)) == $past(uncStatus)));

  a_r4_record_single: assert property (@(posedge clk) disable iff (!rstN)
    recordReq |-> ($countones(recordStatus) == 1));

  a_r8_sse_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sigSysErr) |-> $past(serrEn));
endmodule

bind errsig_classifier errsig_checker #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/tb_errsig_classifier.sv
module tb_errsig_classifier;
  import errsig_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0, evtCorr = 1'b0, evtAdvisory = 1'b0;
  logic [31:0] evtStatus = '0;
  logic [15:0] evtSourceId = '0;
  logic        serrEn = 1'b0, corRptEn = 1'b0, nfRptEn = 1'b0, fatRptEn = 1'b0, urRptEn = 1'b0;
  logic [31:0] corMask = '0, uncMask = '0, uncSeverity = SEV_DEFAULT;
  logic        recordOverflow = 1'b0, msgReady = 1'b1;
  logic        evtReady, recordReq, sigSysErr, msgValid;
  logic [31:0] recordStatus, corStatus, uncStatus;
  logic [3:0]  devStatus;
  logic [2:0]  msgSeverity;
  logic [15:0] msgSourceId;

  int nChecks = 0, nErrors = 0, readyMode = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  errsig_classifier dut (.*);

  // behavioural reference model
  int          mState = 0;
  bit          mOvf = 0, mHlo = 0;
  logic [31:0] mCor = '0, mUnc = '0;
  logic [3:0]  mDev = '0;
  bit          mSse = 0;
  logic [2:0]  mSev = '0;
  logic [15:0] mSrc = '0;

  task automatic evaluate(input bit hlo, output bit rec, output logic [31:0] recBits,
                          output bit send, output logic [2:0] sev,
                          output logic [31:0] nCor, output logic [31:0] nUnc,
                          output logic [3:0] nDev, output bit nSse, output logic [15:0] src);
    bit c = hlo ? 1'b1 : evtCorr;
    bit a = hlo ? 1'b0 : evtAdvisory;
    logic [31:0] s = (hlo ? HLO_BIT : evtStatus) & (c ? COR_SUPPORTED : UNC_SUPPORTED);
    int ones = 0;
    bit ur, fatal;
    for (int i = 0; i < 32; i++) ones += int'(s[i]);
    rec = 0; send = 0; sev = 0; recBits = s;
    nCor = mCor; nUnc = mUnc; nDev = mDev; nSse = mSse;
    src = hlo ? 16'h0 : evtSourceId;
    if (ones != 1) return;
    ur = !c && s[20];
    fatal = !c && ((s & uncSeverity) != 0);
    if (ur) nDev[3] = 1;
    if (c || (a && !fatal)) begin
      logic [31:0] cb = c ? s : 32'h2000;
      nDev[0] = 1;
      nCor = nCor | cb;
      if ((cb & corMask) == 0) begin
        if (!c) begin
          nUnc = nUnc | s;
          rec = ((s & uncMask) == 0);
        end
        send = corRptEn && (!ur || urRptEn);
        sev = 3'b001;
      end
    end else begin
      if (fatal) nDev[2] = 1; else nDev[1] = 1;
      nUnc = nUnc | s;
      if ((s & uncMask) == 0) begin
        rec = 1;
        if (ur && !urRptEn && !serrEn) send = 0;
        else send = serrEn || (fatal ? fatRptEn : nfRptEn);
        sev = fatal ? 3'b100 : 3'b010;
        if (send && serrEn) nSse = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    bit rec, send, nSse;
    logic [31:0] rb, nCor, nUnc;
    logic [3:0] nDev;
    logic [2:0] sev;
    logic [15:0] src;
    if (!rstN) begin
      mState = 0; mOvf = 0; mHlo = 0; mCor = 0; mUnc = 0; mDev = 0; mSse = 0; mSev = 0; mSrc = 0;
    end else begin
      case (mState)
        0: if (evtValid) begin
          evaluate(0, rec, rb, send, sev, nCor, nUnc, nDev, nSse, src);
          mCor = nCor; mUnc = nUnc; mDev = nDev; mSse = nSse;
          if (send) begin
            mSev = sev; mSrc = src; mState = 1; mHlo = 0;
            mOvf = rec && recordOverflow;
          end
        end
        1: if (msgReady) begin
          if (mOvf) begin mState = 2; mOvf = 0; end else mState = 0;
        end
        default: begin
          evaluate(1, rec, rb, send, sev, nCor, nUnc, nDev, nSse, src);
          mCor = nCor; mUnc = nUnc; mDev = nDev; mSse = nSse;
          if (send) begin mSev = sev; mSrc = src; mState = 1; mHlo = 1; end
          else mState = 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit rec, send, nSse;
    logic [31:0] rb, nCor, nUnc;
    logic [3:0] nDev;
    logic [2:0] sev;
    logic [15:0] src;
    if (rstN) begin
      chk("R2 corStatus", corStatus, mCor);
      chk("R4 uncStatus", uncStatus, mUnc);
      chk("R4 devStatus", {28'h0, devStatus}, {28'h0, mDev});
      chk("R8 sigSysErr", {31'h0, sigSysErr}, {31'h0, mSse});
      chk("R9 msgValid", {31'h0, msgValid}, {31'h0, mState == 1});
      chk("R9 evtReady", {31'h0, evtReady}, {31'h0, mState == 0});
      if (mState == 1) begin
        chk(mHlo ? "R10 msgSeverity" : "R7 msgSeverity", {29'h0, msgSeverity}, {29'h0, mSev});
        chk(mHlo ? "R10 msgSourceId" : "R7 msgSourceId", {16'h0, msgSourceId}, {16'h0, mSrc});
      end
      rec = 0; rb = 0;
      if ((mState == 0 && evtValid) || mState == 2)
        evaluate(mState == 2, rec, rb, send, sev, nCor, nUnc, nDev, nSse, src);
      chk("R4 recordReq", {31'h0, recordReq}, {31'h0, rec});
      if (rec) chk("R4 recordStatus", recordStatus, rb);
    end
  end

  always @(posedge clk) begin
    #1;
    msgReady = (readyMode == 0) ? 1'b1 : (($urandom % 4) == 0);
  end

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 0; evtValid = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic fire(input bit c, input bit a, input logic [31:0] s, input logic [15:0] id);
    do begin @(posedge clk); #1; end while (!evtReady);
    evtValid = 1; evtCorr = c; evtAdvisory = a; evtStatus = s; evtSourceId = id;
    @(posedge clk); #1;
    evtValid = 0;
    while (!evtReady) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic setEn(input bit se, input bit ce, input bit ne, input bit fe, input bit ue);
    serrEn = se; corRptEn = ce; nfRptEn = ne; fatRptEn = fe; urRptEn = ue;
  endtask

  initial begin
    #(4 * 150000);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("R11 reset corStatus", corStatus, 0);
    chk("R11 reset uncStatus", uncStatus, 0);
    chk("R11 reset devStatus", {28'h0, devStatus}, 0);
    chk("R11 reset msgValid", {31'h0, msgValid}, 0);
    chk("R11 reset evtReady", {31'h0, evtReady}, 1);

    // R2/R3 correctable, reported
    setEn(0, 1, 0, 0, 0);
    fire(1, 0, 32'h1, 16'h0102);
    chk("R2 cor bit0", corStatus, 32'h1);
    chk("R2 dev cor", {28'h0, devStatus}, 32'h1);

    // R3 masked correctable
    corMask = 32'h40;
    fire(1, 0, 32'h40, 16'h0103);
    chk("R3 masked cor status", corStatus, 32'h41);
    corMask = 0;

    // R1 invalid events
    doReset();
    fire(1, 0, 32'h41, 16'h1);
    fire(1, 0, 32'h2, 16'h1);
    fire(0, 0, 32'h0, 16'h1);
    fire(0, 0, 32'h8, 16'h1);
    chk("R1 ignored cor", corStatus, 0);
    chk("R1 ignored unc", uncStatus, 0);
    chk("R1 ignored dev", {28'h0, devStatus}, 0);

    // R7/R8 fatal with system-error enable
    setEn(1, 0, 0, 0, 0);
    fire(0, 0, 32'h10, 16'h0A0B);
    chk("R4 fatal unc", uncStatus, 32'h10);
    chk("R4 fatal dev", {28'h0, devStatus}, 32'h4);
    chk("R8 sse set", {31'h0, sigSysErr}, 1);

    // R7 non-fatal reported without SERR
    doReset();
    setEn(0, 0, 1, 0, 0);
    fire(0, 0, 32'h4000, 16'h0C0D);
    chk("R4 nonfatal dev", {28'h0, devStatus}, 32'h2);
    chk("R8 no sse", {31'h0, sigSysErr}, 0);

    // R5 masked uncorrectable
    uncMask = 32'h8000;
    fire(0, 0, 32'h8000, 16'h1);
    chk("R5 masked unc", uncStatus, 32'hC000);
    uncMask = 0;

    // R7 unsupported request suppressed
    doReset();
    setEn(0, 0, 1, 0, 0);
    fire(0, 0, UR_BIT, 16'h2);
    chk("R7 ur dev", {28'h0, devStatus}, 32'hA);

    // R6 advisory
    doReset();
    setEn(0, 1, 1, 1, 0);
    fire(0, 1, 32'h1_0000, 16'h3);
    chk("R6 adv cor", corStatus, ADV_BIT);
    chk("R6 adv unc", uncStatus, 32'h1_0000);
    chk("R6 adv dev", {28'h0, devStatus}, 32'h1);
    doReset();
    corMask = ADV_BIT;
    fire(0, 1, 32'h1_0000, 16'h3);
    chk("R6 adv masked unc", uncStatus, 0);
    corMask = 0;
    doReset();
    fire(0, 1, 32'h10, 16'h3);
    chk("R6 fatal not advisory", {28'h0, devStatus}, 32'h4);

    // R10 overflow with stalled handshake
    doReset();
    setEn(0, 1, 0, 1, 0);
    readyMode = 1;
    recordOverflow = 1;
    fire(0, 0, 32'h10, 16'h4);
    recordOverflow = 0;
    chk("R10 hlo cor", corStatus, HLO_BIT);
    chk("R10 dev", {28'h0, devStatus}, 32'h5);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) doReset();
      setEn($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      corMask = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 16)) : 0;
      uncMask = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 0;
      uncSeverity = ($urandom % 2) ? SEV_DEFAULT : $urandom;
      recordOverflow = $urandom % 2;
      readyMode = $urandom % 2;
      fire($urandom % 2, $urandom % 2,
           ($urandom % 5 == 0) ? $urandom : (32'h1 << ($urandom % 32)), 16'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule